// File: doc/BRIEF.md
# PWM Action Qualifier

This block turns the event strobes of a PWM time base into output levels. Each cycle it may receive strobes for counter-equals-zero, counter-equals-period, and compare A or compare B matches, each match split by counting direction. Every output channel has its own action table. The table assigns each of the six events one of four actions: leave the output alone, drive it low, drive it high or invert it. When several strobes arrive together, a fixed priority picks the winner.

Software can act on the outputs in two ways. A one-shot force applies a chosen action once, in the cycle of the write. A continuous override pins a channel low or high. The override sits in a shadow register, and its value moves to the active copy at a chosen point: counter zero, period, either of these, or at once. The outputs are the raw PWM levels, registered. Dead-band generation and trip handling belong to later stages.

Configuration arrives through a simple write port: a write enable, an address and a data word. Nothing is read back.

Top module: `pwm_action_qual`

## Requirements
- R1: After reset both outputs are low. Both action tables are zero, the reload mode is 0, and the shadow and active override values are 0.
- R2: Channel A's table is at address 0 and channel B's at address 1. The action fields in each table are: zero [1:0], period [3:2], compare A counting up [5:4], compare A counting down [7:6], compare B counting up [9:8], compare B counting down [11:10]. A strobe in one cycle updates the output at the next clock edge.
- R3: Action code 0 leaves the output unchanged, 1 drives it low, 2 drives it high and 3 inverts it. With no strobe, no one-shot and no override, the output holds.
- R4: Among simultaneous strobes whose action is not 0, the winner is decided in this order, highest first: compare B up, compare B down, compare A up, compare A down, period, zero. A strobe whose action is 0 does not mask a lower one.
- R5: A write to address 2 is a one-shot force. Bit 4 fires channel A and bit 5 fires channel B. The action for A is in bits [1:0] and the action for B in bits [3:2]. A nonzero forced action overrides every strobe in that cycle. It is applied once, at the edge of the write, and never again.
- R6: An active override value of 1 makes the output load 0 at every edge, and 2 makes it load 1. Strobes and one-shots are ignored while the override is in force. Values 0 and 3 do not override. After the override is released, the output keeps its level until the next action.
- R7: Address 3 writes the shadow override: bits [1:0] for channel A and [3:2] for channel B. Bits [7:6] of a write to address 2 set the reload mode. With mode 0 the active copy loads the shadow on a zero strobe, with mode 1 on a period strobe, and with mode 2 on either. Until that load, a shadow write has no effect on the outputs.
- R8: While the reload mode is 3, the active copy takes the shadow contents at every edge, including a shadow write made in that same cycle. The output follows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_zero | input | 1 | Counter reached zero |
| ev_period | input | 1 | Counter reached period |
| ev_cmpa_up | input | 1 | Compare A match while counting up |
| ev_cmpa_dn | input | 1 | Compare A match while counting down |
| ev_cmpb_up | input | 1 | Compare B match while counting up |
| ev_cmpb_dn | input | 1 | Compare B match while counting down |
| cfg_wr | input | 1 | Configuration write enable |
| cfg_addr | input | $clog2(NUM_CH+2) | Configuration address |
| cfg_wdata | input | DATA_W | Configuration write data |
| pwm_o | output | NUM_CH | PWM levels, bit 0 = channel A, bit 1 = channel B |

## Verification
The bench uses the default parameters: NUM_CH = 2 and DATA_W = 12. With these values the two tables, the force register and the shadow register fill the whole 2-bit address space. Every random write therefore lands on a real register. The 12-bit data word covers every field, so random data reaches every action code, one-shot combination, override value and reload mode. The random phase then pairs these settings with overlapping strobes, which exercises the priority order and the override release.

// File: rtl/pwmaq_pkg.sv
package pwmaq_pkg;

    localparam int NUM_EV = 6;
    localparam int TBL_W  = 2 * NUM_EV;

    // event index equals its field index inside an action table
    localparam int EV_ZRO = 0;
    localparam int EV_PRD = 1;
    localparam int EV_CAU = 2;
    localparam int EV_CAD = 3;
    localparam int EV_CBU = 4;
    localparam int EV_CBD = 5;

    // scan order, lowest priority first: a later entry overrides an earlier one
    localparam int PRIO_ORDER [NUM_EV] = '{EV_ZRO, EV_PRD, EV_CAD, EV_CAU, EV_CBD, EV_CBU};

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOW  = 2'd1,
        ACT_HIGH = 2'd2,
        ACT_TOG  = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        RLD_ZERO   = 2'd0,
        RLD_PRD    = 2'd1,
        RLD_EITHER = 2'd2,
        RLD_NOW    = 2'd3
    } rld_e;

    function automatic logic apply_act(input act_e a, input logic cur);
        case (a)
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            ACT_TOG:  return ~cur;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/pwmaq_regs.sv
module pwmaq_regs
    import pwmaq_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 12,
    parameter int ADDR_W = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic                          ev_zero,
    input  logic                          ev_prd,
    output logic [NUM_CH-1:0][TBL_W-1:0]  tbl_o,
    output logic [NUM_CH-1:0]             os_fire_o,
    output logic [NUM_CH-1:0][1:0]        os_act_o,
    output logic [NUM_CH-1:0][1:0]        hold_o
);

    localparam int ADDR_FRC  = NUM_CH;
    localparam int ADDR_HOLD = NUM_CH + 1;
    localparam int FIRE_LSB  = 2 * NUM_CH;
    localparam int RLD_LSB   = 3 * NUM_CH;

    typedef struct packed {
        logic [NUM_CH-1:0][TBL_W-1:0] tbl;
        rld_e                         rld;
        logic [NUM_CH-1:0][1:0]       shadow;
        logic [NUM_CH-1:0][1:0]       active;
    } regs_s;

    regs_s q, d;
    logic  load;

    always_comb begin
        d = q;
        case (q.rld)
            RLD_ZERO:   load = ev_zero;
            RLD_PRD:    load = ev_prd;
            RLD_EITHER: load = ev_zero | ev_prd;
            default:    load = 1'b0;
        endcase
        if (load) d.active = q.shadow;
        if (wr_en) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (addr == ADDR_W'(i)) d.tbl[i] = wdata[TBL_W-1:0];
            end
            if (addr == ADDR_W'(ADDR_FRC))  d.rld    = rld_e'(wdata[RLD_LSB +: 2]);
            if (addr == ADDR_W'(ADDR_HOLD)) d.shadow = wdata[2*NUM_CH-1:0];
        end
        if (q.rld == RLD_NOW) d.active = d.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            os_fire_o[i] = wr_en && (addr == ADDR_W'(ADDR_FRC)) && wdata[FIRE_LSB + i];
            os_act_o[i]  = wdata[2*i +: 2];
        end
    end

    assign tbl_o  = q.tbl;
    assign hold_o = q.active;

    // R8: immediate mode carries a shadow write straight into the active copy
    p_now_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rld == RLD_NOW && wr_en && addr == ADDR_W'(ADDR_HOLD))
        |=> (hold_o == $past(wdata[2*NUM_CH-1:0])));

    // R7: without a reload point the active override does not move
    p_wait_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rld != RLD_NOW && !ev_zero && !ev_prd) |=> $stable(hold_o));

endmodule

// File: rtl/pwmaq_chan.sv
module pwmaq_chan
    import pwmaq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TBL_W-1:0]  tbl_i,
    input  logic [NUM_EV-1:0] ev_i,
    input  logic              os_fire_i,
    input  logic [1:0]        os_act_i,
    input  logic [1:0]        hold_i,
    output logic              pwm_o
);

    typedef struct packed {
        logic pwm;
    } chan_s;

    chan_s q, d;
    act_e  sel;
    logic  forcing;

    assign forcing = (hold_i == 2'd1) || (hold_i == 2'd2);

    always_comb begin
        sel = ACT_HOLD;
        for (int k = 0; k < NUM_EV; k++) begin
            if (ev_i[PRIO_ORDER[k]] && tbl_i[2*PRIO_ORDER[k] +: 2] != 2'd0)
                sel = act_e'(tbl_i[2*PRIO_ORDER[k] +: 2]);
        end
        if (os_fire_i && os_act_i != 2'd0) sel = act_e'(os_act_i);
        d.pwm = apply_act(sel, q.pwm);
        case (hold_i)
            2'd1:    d.pwm = 1'b0;
            2'd2:    d.pwm = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pwm_o = q.pwm;

    // R6: override pins the level
    p_hold_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i == 2'd1) |=> !pwm_o);
    p_hold_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i == 2'd2) |=> pwm_o);

    // R3: nothing happening means the level holds
    p_quiet_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i == '0 && !os_fire_i && !forcing) |=> (pwm_o == $past(pwm_o)));

    // R5: a forced toggle always changes the level
    p_os_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (os_fire_i && os_act_i == 2'd3 && !forcing) |=> (pwm_o != $past(pwm_o)));

    // R4: compare B counting up outranks every other event
    p_cbu_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i[EV_CBU] && tbl_i[2*EV_CBU +: 2] == 2'd2 && !os_fire_i && !forcing) |=> pwm_o);

endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
    import pwmaq_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ev_zero,
    input  logic                          ev_period,
    input  logic                          ev_cmpa_up,
    input  logic                          ev_cmpa_dn,
    input  logic                          ev_cmpb_up,
    input  logic                          ev_cmpb_dn,
    input  logic                          cfg_wr,
    input  logic [$clog2(NUM_CH+2)-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]             cfg_wdata,
    output logic [NUM_CH-1:0]             pwm_o
);

    localparam int ADDR_W = $clog2(NUM_CH + 2);

    logic [NUM_EV-1:0]            ev_vec;
    logic [NUM_CH-1:0][TBL_W-1:0] tbl;
    logic [NUM_CH-1:0]            os_fire;
    logic [NUM_CH-1:0][1:0]       os_act;
    logic [NUM_CH-1:0][1:0]       hold;

    always_comb begin
        ev_vec         = '0;
        ev_vec[EV_ZRO] = ev_zero;
        ev_vec[EV_PRD] = ev_period;
        ev_vec[EV_CAU] = ev_cmpa_up;
        ev_vec[EV_CAD] = ev_cmpa_dn;
        ev_vec[EV_CBU] = ev_cmpb_up;
        ev_vec[EV_CBD] = ev_cmpb_dn;
    end

    pwmaq_regs #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .ev_zero   (ev_zero),
        .ev_prd    (ev_period),
        .tbl_o     (tbl),
        .os_fire_o (os_fire),
        .os_act_o  (os_act),
        .hold_o    (hold)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        pwmaq_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tbl_i     (tbl[c]),
            .ev_i      (ev_vec),
            .os_fire_i (os_fire[c]),
            .os_act_i  (os_act[c]),
            .hold_i    (hold[c]),
            .pwm_o     (pwm_o[c])
        );
    end

endmodule

// File: tb/pwm_action_qual_bench.sv
module pwm_action_qual_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  ev;      // {cmpb_dn, cmpb_up, cmpa_dn, cmpa_up, period, zero}
    logic        wr;
    logic [1:0]  addr;
    logic [11:0] wdata;
    logic [1:0]  pwm_o;

    always #4 clk = ~clk;

    pwm_action_qual #(.NUM_CH(2), .DATA_W(12)) u_pwm_action_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_zero    (ev[0]),
        .ev_period  (ev[1]),
        .ev_cmpa_up (ev[2]),
        .ev_cmpa_dn (ev[3]),
        .ev_cmpb_up (ev[4]),
        .ev_cmpb_dn (ev[5]),
        .cfg_wr     (wr),
        .cfg_addr   (addr),
        .cfg_wdata  (wdata),
        .pwm_o      (pwm_o)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference state
    logic [1:0][11:0] m_tbl;
    logic [1:0]       m_rld;
    logic [1:0][1:0]  m_sh;
    logic [1:0][1:0]  m_act;
    logic [1:0]       m_pwm;

    function automatic logic do_act(input logic [1:0] a, input logic cur);
        if (a == 2'd1) return 1'b0;
        if (a == 2'd2) return 1'b1;
        if (a == 2'd3) return ~cur;
        return cur;
    endfunction

    task automatic model_step();
        int order [6] = '{4, 5, 2, 3, 1, 0};   // highest priority first
        logic [1:0]      np;
        logic [1:0][1:0] nsh;
        logic            ld;
        for (int c = 0; c < 2; c++) begin
            logic [1:0] a;
            bit found;
            a = 2'd0;
            found = 0;
            if (m_act[c] == 2'd1)      np[c] = 1'b0;
            else if (m_act[c] == 2'd2) np[c] = 1'b1;
            else begin
                if (wr && addr == 2'd2 && wdata[4+c] && wdata[2*c +: 2] != 2'd0) begin
                    a = wdata[2*c +: 2];
                    found = 1;
                end
                for (int k = 0; k < 6; k++) begin
                    if (!found && ev[order[k]] && m_tbl[c][2*order[k] +: 2] != 2'd0) begin
                        a = m_tbl[c][2*order[k] +: 2];
                        found = 1;
                    end
                end
                np[c] = do_act(a, m_pwm[c]);
            end
        end
        nsh = m_sh;
        if (wr && addr == 2'd3) nsh = wdata[3:0];
        ld = (m_rld == 2'd0 && ev[0]) || (m_rld == 2'd1 && ev[1]) ||
             (m_rld == 2'd2 && (ev[0] || ev[1]));
        if (m_rld == 2'd3) m_act = nsh;
        else if (ld)       m_act = m_sh;
        m_sh = nsh;
        if (wr && addr == 2'd0) m_tbl[0] = wdata;
        if (wr && addr == 2'd1) m_tbl[1] = wdata;
        if (wr && addr == 2'd2) m_rld = wdata[7:6];
        m_pwm = np;
    endtask

    // one clock with the currently driven inputs, then compare with the model
    task automatic tick(input string tag);
        model_step();
        @(posedge clk);
        #1;
        n_run++;
        if (pwm_o !== m_pwm) begin
            n_fail++;
            $display("FAIL %s: pwm_o=%b expected %b", tag, pwm_o, m_pwm);
        end
        ev = '0;
        wr = 1'b0;
    endtask

    task automatic expect_lvl(input string tag, input logic [1:0] exp);
        n_run++;
        if (pwm_o !== exp) begin
            n_fail++;
            $display("FAIL %s: pwm_o=%b expected %b", tag, pwm_o, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [11:0] dat, input logic [5:0] e, input string tag);
        wr = 1'b1; addr = a; wdata = dat; ev = e;
        tick(tag);
    endtask

    task automatic strobe(input logic [5:0] e, input string tag);
        ev = e;
        tick(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; ev = '0; wr = 1'b0; addr = '0; wdata = '0;
        m_tbl = '0; m_rld = '0; m_sh = '0; m_act = '0; m_pwm = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        expect_lvl("R1 reset level", 2'b00);
        tick("R1 idle after reset");
        expect_lvl("R1 idle after reset", 2'b00);

        // R2/R3: table layout and action codes
        wr_reg(2'd0, 12'h002, 6'b0, "R2 write table A");
        strobe(6'b000001, "R2 zero high on A");
        expect_lvl("R2 zero high on A", 2'b01);
        wr_reg(2'd1, 12'h420, 6'b0, "R2 write table B");
        strobe(6'b000100, "R2 cmpA up high on B");
        expect_lvl("R2 cmpA up high on B", 2'b11);
        strobe(6'b100000, "R2 cmpB down low on B");
        expect_lvl("R2 cmpB down low on B", 2'b01);
        wr_reg(2'd0, 12'h00C, 6'b0, "R3 period toggle");
        strobe(6'b000010, "R3 toggle one");
        expect_lvl("R3 toggle one", 2'b00);
        strobe(6'b000010, "R3 toggle two");
        expect_lvl("R3 toggle two", 2'b01);
        tick("R3 quiet hold");
        expect_lvl("R3 quiet hold", 2'b01);

        // R4: priority
        wr_reg(2'd1, 12'h000, 6'b0, "R4 clear table B");
        wr_reg(2'd0, 12'h126, 6'b0, "R4 table A");
        strobe(6'b000011, "R4 period beats zero");
        expect_lvl("R4 period beats zero", 2'b00);
        strobe(6'b000111, "R4 cmpA beats period");
        expect_lvl("R4 cmpA beats period", 2'b01);
        strobe(6'b010100, "R4 cmpB beats cmpA");
        expect_lvl("R4 cmpB beats cmpA", 2'b00);
        strobe(6'b001011, "R4 no-change cmpA down does not mask");
        expect_lvl("R4 no-change cmpA down does not mask", 2'b00);

        // R5: one-shot
        wr_reg(2'd2, 12'h012, 6'b010000, "R5 one-shot high beats cmpB");
        expect_lvl("R5 one-shot high beats cmpB", 2'b01);
        wr_reg(2'd2, 12'h013, 6'b0, "R5 one-shot toggle");
        expect_lvl("R5 one-shot toggle", 2'b00);
        tick("R5 applied once");
        expect_lvl("R5 applied once", 2'b00);
        wr_reg(2'd2, 12'h012, 6'b0, "R5 one-shot high");

        // R7/R6: shadowed override, reload at zero
        wr_reg(2'd3, 12'h001, 6'b0, "R7 shadow write no effect");
        expect_lvl("R7 shadow write no effect", 2'b01);
        tick("R7 still waiting");
        expect_lvl("R7 still waiting", 2'b01);
        strobe(6'b000001, "R7 reload at zero");
        expect_lvl("R7 reload at zero", 2'b01);
        tick("R6 override low");
        expect_lvl("R6 override low", 2'b00);
        strobe(6'b000100, "R6 event ignored");
        expect_lvl("R6 event ignored", 2'b00);
        wr_reg(2'd2, 12'h012, 6'b0, "R6 one-shot ignored");
        expect_lvl("R6 one-shot ignored", 2'b00);

        // R8: immediate reload
        wr_reg(2'd2, 12'h0C0, 6'b0, "R8 mode immediate");
        wr_reg(2'd3, 12'h002, 6'b0, "R8 shadow high");
        expect_lvl("R8 shadow high", 2'b00);
        tick("R8 follows one edge later");
        expect_lvl("R8 follows one edge later", 2'b01);
        wr_reg(2'd3, 12'h008, 6'b0, "R8 B high A released");
        expect_lvl("R8 B high A released", 2'b01);
        tick("R6 release keeps level");
        expect_lvl("R6 release keeps level", 2'b11);
        wr_reg(2'd3, 12'h000, 6'b0, "R8 clear shadow");
        wr_reg(2'd2, 12'h000, 6'b0, "R7 mode zero");

        // random phase: R2/R3/R4/R5/R6/R7/R8 against the model
        for (int n = 0; n < 4000; n++) begin
            ev = 6'($urandom & $urandom);
            wr = (($urandom % 8) == 0);
            addr = 2'($urandom);
            wdata = 12'($urandom);
            tick("R4 R6 R7 random");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule